// File: doc/BRIEF.md
# Page Table Walk Step Unit

This block speeds up a software-managed TLB refill by doing the two repeated parts of a multi-level page table walk in hardware. A directory step takes a pointer and a level from 1 to 4. It picks a slice of the faulting virtual address, reads one 64-bit directory word from memory and returns it as the next pointer. A leaf step produces one half of an even/odd page entry pair and the page size. Each level's bit position and slice width come from configuration inputs. The faulting address comes from the refill bad-address input.

Large pages never reach memory. A directory step that meets a huge-page entry tags it with its level and passes it on. A leaf step strips the huge markers and splits the large page into an even half and an odd half. Memory is reached through a simple request/response port, and only one read is in flight at a time. Each step ends with a one-cycle `done_o` pulse.

Entry bit layout used throughout: bit 6 is the huge marker and is also the global bit of a finished entry, bit 12 is the huge-global marker, and bits 14:13 hold the level tag. The physical address mask keeps bits 47:0 by default.

Top module: `ptw_step_unit`

## Requirements
- R1: After reset, `done_o` and `mem_req_o` are 0, and `dir_ptr_o`, `lo_even_o`, `lo_odd_o` and `pgsz_o` are all 0.
- R2: A directory step (`op_leaf_i`=0) with `level_i` equal to 0 or greater than 4 returns `base_i` unchanged on `dir_ptr_o`, issues no memory request, and pulses `done_o` in the cycle after the start.
- R3: A directory step at level 4 whose base has bit 6 set returns `base_i` unchanged and issues no memory request.
- R4: A directory step at levels 1 to 3 whose base has bit 6 set issues no memory request. If the level tag (bits 14:13) is nonzero, the base is returned unchanged. If the tag is zero, the base is returned with bits 14:13 set to `level_i`.
- R5: A normal directory step issues exactly one read at address (base AND physmask) OR (idx << 3). Here idx = (bad address >> position of that level) AND (2^width - 1). `dir_ptr_o` becomes the read data AND physmask.
- R6: A normal leaf step computes idx from configuration slot 0 in the same way, then clears bit 0 of idx. It reads at (base AND physmask) OR (idx << 3) when `odd_i`=0, and at (base AND physmask) OR ((idx+1) << 3) when `odd_i`=1. The masked data goes to `lo_even_o` or `lo_odd_o`, and `pgsz_o` becomes the slot-0 position.
- R7: A leaf step whose masked base has bit 6 set issues no read. The result is the masked base with bits 14:13 and bit 6 cleared. If bit 12 was set, bit 12 is also cleared and bit 6 is set. `pgsz_o` = position + width - 1 of the slot named by the level tag, where tag 0 selects slot 0.
- R8: In a huge leaf step with `odd_i`=1, 2^`pgsz_o` is added to the result. A leaf step writes only the register selected by `odd_i` and leaves the other one unchanged.
- R9: `done_o` is high for exactly one cycle per step. `mem_req_o` is high for one cycle per read. A new read is never issued before the previous response. A start raised while a step is in progress is ignored.
- R10: Configuration slot k (0 = leaf level, 1 to 4 = directory levels) takes its position from `pos_cfg_i[6k+5:6k]` and its width from `wid_cfg_i[6k+5:6k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a step (taken only when idle) |
| op_leaf_i | input | 1 | 0 = directory step, 1 = leaf step |
| level_i | input | 3 | Directory level for a directory step |
| odd_i | input | 1 | Leaf step: 1 selects the odd half |
| base_i | input | 64 | Directory pointer or entry to process |
| badv_i | input | 64 | Faulting virtual address |
| pos_cfg_i | input | 30 | Per-slot index bit positions, 6 bits each |
| wid_cfg_i | input | 30 | Per-slot index widths, 6 bits each |
| mem_req_o | output | 1 | Read request, one cycle |
| mem_addr_o | output | 64 | Read address |
| mem_rsp_i | input | 1 | Read response valid |
| mem_rdata_i | input | 64 | Read response data |
| done_o | output | 1 | Step complete, one cycle |
| dir_ptr_o | output | 64 | Result of the last directory step |
| lo_even_o | output | 64 | Even page entry |
| lo_odd_o | output | 64 | Odd page entry |
| pgsz_o | output | 6 | Page size from the last leaf step |

## Verification
The collision that matters is a new start arriving while the unit is still waiting for a read. The bench raises an illegal-level directory start, with a different base, in the cycle after a normal directory step has been launched. It expects a single `done_o` pulse, a single memory read and the first step's pointer. Memory latency is randomised between one and three cycles, so responses land at varying distances from the following start. Every read address and result is checked against values the bench computes itself.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } ptw_state_e;

   localparam int PTW_CFG_W = 6;
   localparam int PTW_SLOTS = 5;
endpackage

// File: rtl/ptw_cfg_mux.sv
module ptw_cfg_mux #(
   parameter int SLOTS = 5,
   parameter int CFG_W = 6,
   parameter int SW    = 3
) (
   input  logic [SLOTS*CFG_W-1:0] pos_all_i,
   input  logic [SLOTS*CFG_W-1:0] wid_all_i,
   input  logic [SW-1:0]          slot_i,
   output logic [CFG_W-1:0]       pos_o,
   output logic [CFG_W-1:0]       wid_o
);
   logic [CFG_W-1:0] pos_arr [SLOTS];
   logic [CFG_W-1:0] wid_arr [SLOTS];

   for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      assign pos_arr[k] = pos_all_i[k*CFG_W +: CFG_W];
      assign wid_arr[k] = wid_all_i[k*CFG_W +: CFG_W];
   end

   always_comb begin
      pos_o = '0;
      wid_o = '0;
      for (int k = 0; k < SLOTS; k++) begin
         if (slot_i == SW'(k)) begin
            pos_o = pos_arr[k];
            wid_o = wid_arr[k];
         end
      end
   end
endmodule

// File: rtl/ptw_index_gen.sv
module ptw_index_gen #(
   parameter int DW    = 64,
   parameter int CFG_W = 6
) (
   input  logic [DW-1:0]    badv_i,
   input  logic [CFG_W-1:0] pos_i,
   input  logic [CFG_W-1:0] wid_i,
   input  logic             pair_i,
   input  logic             odd_i,
   output logic [DW-1:0]    offset_o
);
   localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

   logic [DW-1:0] wmask;
   logic [DW-1:0] raw_idx;
   logic [DW-1:0] idx;

   always_comb begin
      wmask   = (ONE << wid_i) - ONE;
      raw_idx = (badv_i >> pos_i) & wmask;
      idx     = raw_idx;
      if (pair_i) begin
         idx[0] = 1'b0;
         if (odd_i) idx = idx + ONE;
      end
      offset_o = idx << 3;
   end
endmodule

// File: rtl/ptw_huge_leaf.sv
module ptw_huge_leaf #(
   parameter int DW       = 64,
   parameter int CFG_W    = 6,
   parameter int HUGE_BIT = 6,
   parameter int GLB_BIT  = 6,
   parameter int HGLB_BIT = 12,
   parameter int LVL_LSB  = 13,
   parameter int LVL_W    = 2
) (
   input  logic [DW-1:0]    entry_i,
   input  logic [CFG_W-1:0] pos_i,
   input  logic [CFG_W-1:0] wid_i,
   input  logic             odd_i,
   output logic [DW-1:0]    entry_o,
   output logic [CFG_W-1:0] ps_o
);
   localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

   logic [DW-1:0] stripped;

   always_comb begin
      ps_o     = pos_i + wid_i - CFG_W'(1);
      stripped = entry_i;
      stripped[LVL_LSB +: LVL_W] = '0;
      stripped[HUGE_BIT]         = 1'b0;
      if (entry_i[HGLB_BIT]) begin
         stripped[HGLB_BIT] = 1'b0;
         stripped[GLB_BIT]  = 1'b1;
      end
      entry_o = odd_i ? stripped + (ONE << ps_o) : stripped;
   end
endmodule

// File: rtl/ptw_step_unit.sv
module ptw_step_unit
   import ptw_pkg::*;
#(
   parameter int DW        = 64,
   parameter int PA_BITS   = 48,
   parameter int HUGE_BIT  = 6,
   parameter int GLB_BIT   = 6,
   parameter int HGLB_BIT  = 12,
   parameter int LVL_LSB   = 13,
   parameter int LVL_W     = 2,
   parameter int MAX_LEVEL = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start_i,
   input  logic                           op_leaf_i,
   input  logic [2:0]                     level_i,
   input  logic                           odd_i,
   input  logic [DW-1:0]                  base_i,
   input  logic [DW-1:0]                  badv_i,
   input  logic [PTW_SLOTS*PTW_CFG_W-1:0] pos_cfg_i,
   input  logic [PTW_SLOTS*PTW_CFG_W-1:0] wid_cfg_i,
   output logic                           mem_req_o,
   output logic [DW-1:0]                  mem_addr_o,
   input  logic                           mem_rsp_i,
   input  logic [DW-1:0]                  mem_rdata_i,
   output logic                           done_o,
   output logic [DW-1:0]                  dir_ptr_o,
   output logic [DW-1:0]                  lo_even_o,
   output logic [DW-1:0]                  lo_odd_o,
   output logic [PTW_CFG_W-1:0]           pgsz_o
);
   localparam int SW = $clog2(PTW_SLOTS);

   if (PA_BITS < 1 || PA_BITS > DW) begin : g_bad_pa
      $error("PA_BITS must lie in 1..DW");
   end
   if (LVL_LSB + LVL_W > DW || HGLB_BIT >= DW || HUGE_BIT >= DW) begin : g_bad_fields
      $error("entry field positions exceed the data width");
   end
   if ((1 << LVL_W) < MAX_LEVEL) begin : g_bad_lvlw
      $error("level tag too narrow for MAX_LEVEL-1");
   end
   if (MAX_LEVEL >= PTW_SLOTS || MAX_LEVEL > 7) begin : g_bad_maxlvl
      $error("MAX_LEVEL needs a configuration slot and must fit level_i");
   end

   logic [DW-1:0] pa_mask;
   if (PA_BITS == DW) begin : g_pa_full
      assign pa_mask = '1;
   end else begin : g_pa_part
      assign pa_mask = ({{(DW-1){1'b0}}, 1'b1} << PA_BITS) - {{(DW-1){1'b0}}, 1'b1};
   end

   ptw_state_e            state_q;
   logic                  leaf_q, odd_q, done_q;
   logic [DW-1:0]         addr_q, dir_q, even_q, oddr_q;
   logic [PTW_CFG_W-1:0]  ps_q, pend_ps_q;

   logic                  idle_w, accept;
   logic [DW-1:0]         base_m;
   logic [LVL_W-1:0]      tag_raw, tag_m;
   logic                  dir_legal, huge_raw, huge_m;
   logic [SW-1:0]         slot;
   logic [PTW_CFG_W-1:0]  cfg_pos, cfg_wid;
   logic [DW-1:0]         offset;
   logic [DW-1:0]         huge_entry;
   logic [PTW_CFG_W-1:0]  huge_ps;
   logic [DW-1:0]         tagged_base;

   assign idle_w    = (state_q == ST_IDLE);
   assign accept    = start_i && idle_w;
   assign base_m    = base_i & pa_mask;
   assign tag_raw   = base_i[LVL_LSB +: LVL_W];
   assign tag_m     = base_m[LVL_LSB +: LVL_W];
   assign huge_raw  = base_i[HUGE_BIT];
   assign huge_m    = base_m[HUGE_BIT];
   assign dir_legal = (level_i != 3'd0) && (level_i <= 3'(MAX_LEVEL));

   always_comb begin
      if (op_leaf_i) slot = huge_m ? SW'(tag_m) : '0;
      else           slot = dir_legal ? SW'(level_i) : '0;
   end

   always_comb begin
      tagged_base = base_i;
      tagged_base[LVL_LSB +: LVL_W] = LVL_W'(level_i);
   end

   ptw_cfg_mux #(
      .SLOTS(PTW_SLOTS), .CFG_W(PTW_CFG_W), .SW(SW)
   ) u_cfg (
      .pos_all_i(pos_cfg_i), .wid_all_i(wid_cfg_i), .slot_i(slot),
      .pos_o(cfg_pos), .wid_o(cfg_wid)
   );

   ptw_index_gen #(
      .DW(DW), .CFG_W(PTW_CFG_W)
   ) u_idx (
      .badv_i(badv_i), .pos_i(cfg_pos), .wid_i(cfg_wid),
      .pair_i(op_leaf_i), .odd_i(odd_i), .offset_o(offset)
   );

   ptw_huge_leaf #(
      .DW(DW), .CFG_W(PTW_CFG_W), .HUGE_BIT(HUGE_BIT), .GLB_BIT(GLB_BIT),
      .HGLB_BIT(HGLB_BIT), .LVL_LSB(LVL_LSB), .LVL_W(LVL_W)
   ) u_huge (
      .entry_i(base_m), .pos_i(cfg_pos), .wid_i(cfg_wid), .odd_i(odd_i),
      .entry_o(huge_entry), .ps_o(huge_ps)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         leaf_q    <= 1'b0;
         odd_q     <= 1'b0;
         done_q    <= 1'b0;
         addr_q    <= '0;
         dir_q     <= '0;
         even_q    <= '0;
         oddr_q    <= '0;
         ps_q      <= '0;
         pend_ps_q <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  leaf_q <= op_leaf_i;
                  odd_q  <= odd_i;
                  if (!op_leaf_i) begin
                     if (!dir_legal) begin
                        dir_q  <= base_i;
                        done_q <= 1'b1;
                     end else if (huge_raw) begin
                        if (level_i == 3'(MAX_LEVEL) || tag_raw != '0) dir_q <= base_i;
                        else                                            dir_q <= tagged_base;
                        done_q <= 1'b1;
                     end else begin
                        addr_q  <= base_m | offset;
                        state_q <= ST_REQ;
                     end
                  end else begin
                     if (huge_m) begin
                        if (odd_i) oddr_q <= huge_entry;
                        else       even_q <= huge_entry;
                        ps_q   <= huge_ps;
                        done_q <= 1'b1;
                     end else begin
                        addr_q    <= base_m | offset;
                        pend_ps_q <= cfg_pos;
                        state_q   <= ST_REQ;
                     end
                  end
               end
            end
            ST_REQ: state_q <= ST_WAIT;
            ST_WAIT: begin
               if (mem_rsp_i) begin
                  if (leaf_q) begin
                     if (odd_q) oddr_q <= mem_rdata_i & pa_mask;
                     else       even_q <= mem_rdata_i & pa_mask;
                     ps_q <= pend_ps_q;
                  end else begin
                     dir_q <= mem_rdata_i & pa_mask;
                  end
                  done_q  <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req_o  = (state_q == ST_REQ);
   assign mem_addr_o = addr_q;
   assign done_o     = done_q;
   assign dir_ptr_o  = dir_q;
   assign lo_even_o  = even_q;
   assign lo_odd_o   = oddr_q;
   assign pgsz_o     = ps_q;
endmodule

// File: rtl/ptw_step_unit_chk.sv
module ptw_step_unit_chk #(
   parameter int DW       = 64,
   parameter int HUGE_BIT = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          idle,
   input logic          start_i,
   input logic          op_leaf_i,
   input logic [2:0]    level_i,
   input logic [DW-1:0] base_i,
   input logic          mem_req_o,
   input logic          mem_rsp_i,
   input logic          done_o,
   input logic [DW-1:0] dir_ptr_o
);
   logic take;
   assign take = start_i && idle;

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |=> !mem_req_o);

   assert_illegal_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !op_leaf_i && (level_i == 3'd0 || level_i > 3'd4))
      |=> (done_o && !mem_req_o && dir_ptr_o == $past(base_i)));

   assert_huge_l4_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !op_leaf_i && level_i == 3'd4 && base_i[HUGE_BIT])
      |=> (done_o && !mem_req_o && dir_ptr_o == $past(base_i)));

   assert_huge_dir_noread_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !op_leaf_i && level_i != 3'd0 && level_i < 3'd4 && base_i[HUGE_BIT])
      |=> (done_o && !mem_req_o));

   assert_normal_dir_reads_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !op_leaf_i && level_i != 3'd0 && level_i <= 3'd4 && !base_i[HUGE_BIT])
      |=> (mem_req_o && !done_o));

   assert_huge_leaf_noread_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && op_leaf_i && base_i[HUGE_BIT]) |=> (done_o && !mem_req_o));

   assert_no_done_on_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> !done_o);
endmodule

bind ptw_step_unit ptw_step_unit_chk #(.DW(DW), .HUGE_BIT(HUGE_BIT)) u_chk (
   .clk(clk), .rst_n(rst_n), .idle(idle_w), .start_i(start_i),
   .op_leaf_i(op_leaf_i), .level_i(level_i), .base_i(base_i),
   .mem_req_o(mem_req_o), .mem_rsp_i(mem_rsp_i), .done_o(done_o),
   .dir_ptr_o(dir_ptr_o)
);

// File: tb/ptw_step_unit_test.sv
module ptw_step_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam logic [63:0] PAM = 64'h0000_FFFF_FFFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, op_leaf_i = 1'b0, odd_i = 1'b0;
   logic [2:0]  level_i = 3'd0;
   logic [63:0] base_i = '0, badv_i = '0;
   logic [29:0] pos_cfg_i = '0, wid_cfg_i = '0;
   logic        mem_req_o, mem_rsp_i = 1'b0, done_o;
   logic [63:0] mem_addr_o, mem_rdata_i = '0, dir_ptr_o, lo_even_o, lo_odd_o;
   logic [5:0]  pgsz_o;

   int n_chk = 0, n_fail = 0, n_req = 0, n_done = 0;
   logic [63:0] last_addr = '0;
   logic [5:0]  bpos [5];
   logic [5:0]  bwid [5];
   logic [63:0] m_even = '0, m_odd = '0;
   logic [5:0]  m_ps = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ptw_step_unit uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_leaf_i(op_leaf_i),
      .level_i(level_i), .odd_i(odd_i), .base_i(base_i), .badv_i(badv_i),
      .pos_cfg_i(pos_cfg_i), .wid_cfg_i(wid_cfg_i), .mem_req_o(mem_req_o),
      .mem_addr_o(mem_addr_o), .mem_rsp_i(mem_rsp_i), .mem_rdata_i(mem_rdata_i),
      .done_o(done_o), .dir_ptr_o(dir_ptr_o), .lo_even_o(lo_even_o),
      .lo_odd_o(lo_odd_o), .pgsz_o(pgsz_o)
   );

   function automatic logic [63:0] mem_val(logic [63:0] a);
      return {a[31:0] ^ 32'hC3A5_5A3C, a[63:32] ^ 32'h1F2E_3D4C} ^ {a[15:0], 48'h0};
   endfunction

   function automatic logic [63:0] slice_off(logic [63:0] bv, int s, bit pair, bit odd);
      logic [63:0] ix;
      ix = (bv >> bpos[s]) & ((64'd1 << bwid[s]) - 64'd1);
      if (pair) begin
         ix[0] = 1'b0;
         if (odd) ix = ix + 64'd1;
      end
      return ix << 3;
   endfunction

   task automatic chk(input string req, input bit ok, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply_cfg();
      for (int k = 0; k < 5; k++) begin
         pos_cfg_i[6*k +: 6] = bpos[k];
         wid_cfg_i[6*k +: 6] = bwid[k];
      end
   endtask

   // memory model and done counter, driven at the falling edge
   initial begin
      bit pend = 0;
      int cnt = 0;
      forever begin
         @(negedge clk);
         mem_rsp_i = 1'b0;
         if (done_o) n_done++;
         if (pend) begin
            if (cnt == 0) begin
               mem_rsp_i   = 1'b1;
               mem_rdata_i = mem_val(last_addr);
               pend = 0;
            end else cnt--;
         end
         if (mem_req_o) begin
            last_addr = mem_addr_o;
            pend = 1;
            cnt = int'($urandom % 3);
            n_req++;
         end
      end
   end

   // run one step; returns number of reads it made
   task automatic step(input bit leaf, input logic [2:0] lvl, input bit odd,
                       input logic [63:0] base, output int reads, output bit seen);
      int r0, d0;
      r0 = n_req;
      @(negedge clk);
      op_leaf_i = leaf; level_i = lvl; odd_i = odd; base_i = base; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      d0 = n_done;
      seen = 0;
      for (int t = 0; t < 30 && !seen; t++) begin
         if (done_o) seen = 1;
         else @(negedge clk);
      end
      reads = n_req - r0;
      if (seen) begin
         @(negedge clk);
         chk("R9 done single cycle", !done_o, {63'd0, done_o}, 64'd0);
      end
      chk("R9 step completes", seen, {63'd0, seen}, 64'd1);
      if (d0 < 0) reads = -1;
   endtask

   task automatic run_dir(input logic [2:0] lvl, input logic [63:0] base);
      int rd; bit sn;
      logic [63:0] exp, ea;
      step(0, lvl, 0, base, rd, sn);
      if (lvl == 0 || lvl > 4) begin
         chk("R2 illegal level returns base", dir_ptr_o == base, dir_ptr_o, base);
         chk("R2 illegal level no read", rd == 0, 64'(rd), 0);
      end else if (base[6]) begin
         exp = base;
         if (lvl != 4 && base[14:13] == 2'd0) exp[14:13] = lvl[1:0];
         chk(lvl == 4 ? "R3 huge level4 unchanged" : "R4 huge tag", dir_ptr_o == exp, dir_ptr_o, exp);
         chk("R4 huge no read", rd == 0, 64'(rd), 0);
      end else begin
         ea = (base & PAM) | slice_off(badv_i, int'(lvl), 0, 0);
         chk("R5 one read", rd == 1, 64'(rd), 1);
         chk("R5 R10 read address", last_addr == ea, last_addr, ea);
         exp = mem_val(ea) & PAM;
         chk("R5 masked pointer", dir_ptr_o == exp, dir_ptr_o, exp);
      end
   endtask

   task automatic run_leaf(input bit odd, input logic [63:0] base);
      int rd; bit sn; int s;
      logic [63:0] bm, e, ea;
      logic [5:0] ps;
      step(1, 3'd0, odd, base, rd, sn);
      bm = base & PAM;
      if (bm[6]) begin
         s = int'(bm[14:13]);
         ps = bpos[s] + bwid[s] - 6'd1;
         e = bm; e[14:13] = 2'b00; e[6] = 1'b0;
         if (bm[12]) begin e[12] = 1'b0; e[6] = 1'b1; end
         if (odd) e = e + (64'd1 << ps);
         chk("R7 huge leaf no read", rd == 0, 64'(rd), 0);
         chk("R7 huge page size", pgsz_o == ps, 64'(pgsz_o), 64'(ps));
      end else begin
         ea = bm | slice_off(badv_i, 0, 1, odd);
         ps = bpos[0];
         chk("R6 one read", rd == 1, 64'(rd), 1);
         chk("R6 pair address", last_addr == ea, last_addr, ea);
         chk("R6 page size", pgsz_o == ps, 64'(pgsz_o), 64'(ps));
         e = mem_val(ea) & PAM;
      end
      if (odd) m_odd = e; else m_even = e;
      chk(odd ? "R8 odd entry" : "R6 R7 even entry", (odd ? lo_odd_o : lo_even_o) == e,
          odd ? lo_odd_o : lo_even_o, e);
      chk("R8 other half untouched", (odd ? lo_even_o : lo_odd_o) == (odd ? m_even : m_odd),
          odd ? lo_even_o : lo_odd_o, odd ? m_even : m_odd);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [63:0] b;
      int rd0, dn0;
      void'($urandom(32'd20240517));
      bpos[0] = 6'd12; bwid[0] = 6'd9;
      bpos[1] = 6'd21; bwid[1] = 6'd9;
      bpos[2] = 6'd30; bwid[2] = 6'd9;
      bpos[3] = 6'd39; bwid[3] = 6'd9;
      bpos[4] = 6'd48; bwid[4] = 6'd7;
      apply_cfg();
      badv_i = 64'h0000_7A5C_3E1F_9D40;
      repeat (3) @(negedge clk);
      chk("R1 done low", done_o == 0, {63'd0, done_o}, 0);
      chk("R1 req low", mem_req_o == 0, {63'd0, mem_req_o}, 0);
      chk("R1 results zero", (dir_ptr_o | lo_even_o | lo_odd_o | 64'(pgsz_o)) == 0,
          dir_ptr_o | lo_even_o | lo_odd_o, 0);
      rst_n = 1'b1;

      // directed corners
      run_dir(3'd0, 64'hDEAD_BEEF_0000_1000);
      run_dir(3'd5, 64'h1234_0000_0000_2000);
      run_dir(3'd7, 64'h1234_0000_0000_3000);
      run_dir(3'd4, 64'h0000_0001_0000_0040);
      run_dir(3'd2, 64'h0000_0001_0000_0040);
      run_dir(3'd3, 64'h0000_0001_0000_4040);
      for (int l = 1; l <= 4; l++) run_dir(3'(l), 64'hFFFF_0012_3456_7000);
      run_leaf(0, 64'h0000_0000_0AB0_0000);
      run_leaf(1, 64'h0000_0000_0AB0_0000);
      run_leaf(0, 64'h0000_0008_0000_1040);
      run_leaf(1, 64'h0000_0008_0000_2040);
      run_leaf(1, 64'h0000_0000_4000_6040);

      // start while busy is ignored
      @(negedge clk);
      op_leaf_i = 0; level_i = 3'd2; base_i = 64'h0000_0000_0055_0000; start_i = 1'b1;
      rd0 = n_req; dn0 = n_done;
      @(negedge clk);
      level_i = 3'd0; base_i = 64'h0BAD_0BAD_0BAD_0BAD;
      @(negedge clk);
      start_i = 1'b0;
      repeat (10) @(negedge clk);
      b = mem_val(64'h0000_0000_0055_0000 | slice_off(badv_i, 2, 0, 0)) & PAM;
      chk("R9 busy start ignored", dir_ptr_o == b, dir_ptr_o, b);
      chk("R9 single read", n_req - rd0 == 1, 64'(n_req - rd0), 1);
      chk("R9 single done", n_done - dn0 == 1, 64'(n_done - dn0), 1);

      // constrained random
      for (int it = 0; it < 60; it++) begin
         int kind;
         if (it % 15 == 0) begin
            for (int k = 0; k < 5; k++) begin
               bpos[k] = 6'(3 + $urandom % 45);
               bwid[k] = 6'(1 + $urandom % 11);
            end
            apply_cfg();
         end
         badv_i = {$urandom, $urandom};
         b = {$urandom, $urandom};
         kind = int'($urandom % 5);
         case (kind)
            0: begin b[6] = 0; run_dir(3'(1 + $urandom % 4), b); end
            1: run_dir(($urandom % 2) ? 3'd0 : 3'(5 + $urandom % 3), b);
            2: begin b[6] = 1; run_dir(3'(1 + $urandom % 4), b); end
            3: begin b[6] = 0; run_leaf(bit'($urandom % 2), b); end
            default: begin b[6] = 1; run_leaf(bit'($urandom % 2), b); end
         endcase
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule